// File: doc/BRIEF.md
# Holdover Frequency Averager

This block watches the frequency control word of a clock-recovery loop. It keeps a long sliding-window average of that word so that, when the clock later drops into holdover, it can hand over a frequency taken from history and known to be good. Each `tick` pulse stands for one second. The tick spacing is an input, so a test can run the block on a scaled time base. On each tick the block takes one sample of `freq_word`. It skips the sample while the loop reports loss of reference (`lor`) or fast acquisition (`fast_acq`). Accepted samples are summed in blocks of `TPB`. The last `NBLK` block sums stay in a ring with a running total. Each new block yields a fresh average, which enters a delay line `DELAY_BLOCKS` deep. Only the entry that leaves the far end of that line reaches the output. This keeps the handed-over value older than any recent frequency-limit alarm.

A small controller has three states. `HS_UNQUAL` means no qualification since reset. `hold_word` then carries the fixed free-run word and `hold_good` is low. `HS_GOOD` means the qualification time has passed. `hold_good` is high and `hold_word` follows the aged averages. `HS_RELOCK` means a reference change arrived after an earlier qualification. `hold_good` is low and `hold_word` keeps the last value it was given.

The transitions are as follows:
- UNQUAL→GOOD and RELOCK→GOOD on the qualifying tick.
- GOOD→RELOCK on `ref_change`.
- UNQUAL stays UNQUAL on `ref_change`, but its qualification count restarts.

Top module: `holdover_averager`

## Requirements
- R1: After reset, `hold_good` is 0 and `hold_word` equals `FREE_RUN`.
- R2: `hold_good` rises at the clock edge of the `QUAL_TICKS`-th tick (default 101) counted since reset or since the last `ref_change`. Every tick counts toward this, whether or not a sample is inhibited.
- R3: A `ref_change` pulse clears `hold_good` at the next edge. It restarts the qualification count and discards the partial block, the window contents and the delay line. A tick in the same cycle as `ref_change` is ignored.
- R4: A block completes on each `TPB`-th accepted sample (default 8). Its average is floor(S / (TPB·B)), where B is the number of block sums held (at most `NBLK`, default 131, oldest dropped first) and S is their sum.
- R5: A tick while `lor` or `fast_acq` is 1 does not accept a sample, so no block completes and `hold_word` keeps its value.
- R6: Until the first qualification after reset, `hold_word` stays at `FREE_RUN`.
- R7: `hold_word` loads only when a block completes while the state was already GOOD before that edge. The value loaded is the average computed `DELAY_BLOCKS` blocks earlier (default 4). That average is pushed out of the delay line by the newer one. In RELOCK, `hold_word` keeps its last value.
- R8: In cycles without `tick` or `ref_change`, neither output changes, whatever `freq_word` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | W | Loop frequency control word, sampled on ticks |
| tick | input | 1 | One-cycle pulse per (scaled) second |
| ref_change | input | 1 | One-cycle pulse: a reference was selected or changed |
| lor | input | 1 | Loss of reference; inhibits sampling |
| fast_acq | input | 1 | Fast acquisition active; inhibits sampling |
| hold_word | output | W | Frequency word to use on holdover entry |
| hold_good | output | 1 | History is qualified |

## Verification
Every result appears at the clock edge that consumes its stimulus, with no extra register stage:
- `hold_good` falls on the edge that sees `ref_change` and rises on the edge of the qualifying tick.
- `hold_word` moves on the edge of the tick that completes a block. It then shows the average from `DELAY_BLOCKS` blocks before.

The bench drives inputs and compares outputs on the falling edge. A behavioural queue model advances on the rising edge, so each compare sees exactly the edge just taken. Directed checks use constant input words, for which every expected average is known by hand. They land on the 100th and 101st tick and on the first cycle after a reference change.

// File: rtl/holdover_avg_pkg.sv
package holdover_avg_pkg;
    typedef enum logic [1:0] {
        HS_UNQUAL = 2'd0,
        HS_GOOD   = 2'd1,
        HS_RELOCK = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hov_block_acc.sv
// Sums accepted per-tick samples into blocks of TPB samples.
module hov_block_acc #(
    parameter int W   = 24,
    parameter int TPB = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                tick,
    input  logic                                inhibit,
    input  logic [W-1:0]                        sample,
    output logic                                done,
    output logic [W+$clog2(TPB+1)-1:0]          blk_sum
);
    localparam int CW = $clog2(TPB + 1);
    localparam int SW = W + $clog2(TPB + 1);

    logic [CW-1:0] cnt;
    logic [SW-1:0] acc;
    logic          accept;

    assign accept  = tick && !inhibit && !clear;
    assign done    = accept && (cnt == CW'(TPB - 1));
    assign blk_sum = acc + SW'(sample);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            acc <= '0;
        end else if (accept) begin
            if (done) begin
                cnt <= '0;
                acc <= '0;
            end else begin
                cnt <= cnt + CW'(1);
                acc <= blk_sum;
            end
        end
    end

    // Inhibited ticks must not advance the sample count.
    assert_no_sample_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && inhibit && !clear) |=> $stable(cnt));
    // A block never holds more than TPB samples.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TPB));
endmodule

// File: rtl/hov_window.sv
// Ring of the last NBLK block sums with a running total; average of new total.
module hov_window #(
    parameter int W    = 24,
    parameter int TPB  = 8,
    parameter int NBLK = 131
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                push,
    input  logic [W+$clog2(TPB+1)-1:0]          blk_sum,
    output logic [W-1:0]                        avg
);
    localparam int BSW = W + $clog2(TPB + 1);
    localparam int TW  = BSW + $clog2(NBLK + 1);
    localparam int PW  = $clog2(NBLK);
    localparam int FW  = $clog2(NBLK + 1);
    localparam int DW  = FW + $clog2(TPB + 1);

    logic [BSW-1:0] ring [NBLK];
    logic [PW-1:0]  wr_ptr;
    logic [FW-1:0]  fill, fill_nx;
    logic [TW-1:0]  total, total_nx;
    logic [DW-1:0]  divisor;
    logic           full;

    assign full     = (fill == FW'(NBLK));
    assign fill_nx  = full ? fill : fill + FW'(1);
    assign total_nx = total + TW'(blk_sum) - (full ? TW'(ring[wr_ptr]) : '0);
    assign divisor  = DW'(fill_nx) * DW'(TPB);
    assign avg      = W'(total_nx / TW'(divisor));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            fill   <= '0;
            total  <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == PW'(NBLK - 1)) ? '0 : wr_ptr + PW'(1);
            fill   <= fill_nx;
            total  <= total_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) begin
            ring[wr_ptr] <= blk_sum;
        end
    end

    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(NBLK));
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0));
endmodule

// File: rtl/hov_delay_line.sv
// DEPTH-stage shift line of averages; advances once per completed block.
module hov_delay_line #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_valid
);
    for (genvar g = 0; g < DEPTH; g++) begin : gen_stage
        logic         v;
        logic [W-1:0] d;
        logic         v_in;
        logic [W-1:0] d_in;
        if (g == 0) begin : gen_head
            assign v_in = 1'b1;
            assign d_in = din;
        end else begin : gen_body
            assign v_in = gen_stage[g-1].v;
            assign d_in = gen_stage[g-1].d;
        end
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                v <= 1'b0;
            end else if (push) begin
                v <= v_in;
            end
        end
        always_ff @(posedge clk) begin
            if (push) begin
                d <= d_in;
            end
        end
    end

    assign dout       = gen_stage[DEPTH-1].d;
    assign dout_valid = gen_stage[DEPTH-1].v;

    assert_head_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |=> gen_stage[0].v);
endmodule

// File: rtl/holdover_averager.sv
module holdover_averager
    import holdover_avg_pkg::*;
#(
    parameter int          W            = 24,
    parameter int          TPB          = 8,
    parameter int          NBLK         = 131,
    parameter int          QUAL_TICKS   = 101,
    parameter int          DELAY_BLOCKS = 4,
    parameter logic [23:0] FREE_RUN     = 24'h800000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] freq_word,
    input  logic         tick,
    input  logic         ref_change,
    input  logic         lor,
    input  logic         fast_acq,
    output logic [W-1:0] hold_word,
    output logic         hold_good
);
    localparam int QW  = $clog2(QUAL_TICKS + 1);
    localparam int BSW = W + $clog2(TPB + 1);

    hs_state_e     state_q, state_d;
    logic [QW-1:0] qual_cnt;
    logic          qual_hit;
    logic          blk_done;
    logic [BSW-1:0] blk_sum;
    logic [W-1:0]  win_avg;
    logic [W-1:0]  dl_out;
    logic          dl_valid;
    logic [W-1:0]  hold_q;

    hov_block_acc #(.W(W), .TPB(TPB)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ref_change),
        .tick    (tick),
        .inhibit (lor || fast_acq),
        .sample  (freq_word),
        .done    (blk_done),
        .blk_sum (blk_sum)
    );

    hov_window #(.W(W), .TPB(TPB), .NBLK(NBLK)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ref_change),
        .push    (blk_done),
        .blk_sum (blk_sum),
        .avg     (win_avg)
    );

    hov_delay_line #(.W(W), .DEPTH(DELAY_BLOCKS)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (ref_change),
        .push       (blk_done),
        .din        (win_avg),
        .dout       (dl_out),
        .dout_valid (dl_valid)
    );

    assign qual_hit = tick && !ref_change && (state_q != HS_GOOD)
                      && (qual_cnt == QW'(QUAL_TICKS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_UNQUAL: if (qual_hit)   state_d = HS_GOOD;
            HS_GOOD:   if (ref_change) state_d = HS_RELOCK;
            HS_RELOCK: if (qual_hit)   state_d = HS_GOOD;
            default:                   state_d = HS_UNQUAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HS_UNQUAL;
            qual_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (ref_change || qual_hit) begin
                qual_cnt <= '0;
            end else if (tick && state_q != HS_GOOD) begin
                qual_cnt <= qual_cnt + QW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= W'(FREE_RUN);
        end else if (blk_done && dl_valid && state_q == HS_GOOD) begin
            hold_q <= dl_out;
        end
    end

    assign hold_word = hold_q;
    assign hold_good = (state_q == HS_GOOD);

    assert_good_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_change |=> !hold_good);
    assert_good_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_good && !tick) |=> !hold_good);
    assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_UNQUAL) |-> (hold_word == W'(FREE_RUN)));
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HS_GOOD || ref_change || !tick) |=> $stable(hold_word));
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ref_change) |=> ($stable(hold_word) && $stable(hold_good)));
endmodule

// File: tb/holdover_averager_test.sv
`timescale 1ns/1ps
module holdover_averager_test;
    localparam int          W    = 24;
    localparam int          TPB  = 8;
    localparam int          NBLK = 131;
    localparam int          QUAL = 101;
    localparam int          DLY  = 4;
    localparam logic [23:0] FR   = 24'h800000;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [W-1:0] freq_word = '0;
    logic         tick = 0, ref_change = 0, lor = 0, fast_acq = 0;
    logic [W-1:0] hold_word;
    logic         hold_good;

    int checks = 0, fails = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    holdover_averager #(.W(W), .TPB(TPB), .NBLK(NBLK), .QUAL_TICKS(QUAL),
                        .DELAY_BLOCKS(DLY), .FREE_RUN(FR)) uut (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .tick(tick),
        .ref_change(ref_change), .lor(lor), .fast_acq(fast_acq),
        .hold_word(hold_word), .hold_good(hold_good));

    // Behavioural model
    int      m_qcnt, m_nblk;
    bit      m_good;
    longint  m_acc, m_hold;
    longint  m_sums[$];
    longint  m_pipe[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_qcnt = 0; m_nblk = 0; m_good = 0; m_acc = 0; m_hold = FR;
            m_sums.delete(); m_pipe.delete();
        end else if (ref_change) begin
            m_qcnt = 0; m_good = 0; m_nblk = 0; m_acc = 0;
            m_sums.delete(); m_pipe.delete();
        end else if (tick) begin
            bit was_good;
            was_good = m_good;
            if (!m_good) begin
                m_qcnt++;
                if (m_qcnt == QUAL) begin m_good = 1; m_qcnt = 0; end
            end
            if (!(lor || fast_acq)) begin
                m_acc += longint'(freq_word);
                m_nblk++;
                if (m_nblk == TPB) begin
                    longint tot;
                    m_sums.push_back(m_acc);
                    if (m_sums.size() > NBLK) void'(m_sums.pop_front());
                    tot = 0;
                    foreach (m_sums[i]) tot += m_sums[i];
                    m_pipe.push_back(tot / (longint'(m_sums.size()) * TPB));
                    if (m_pipe.size() > DLY) begin
                        longint v;
                        v = m_pipe.pop_front();
                        if (was_good) m_hold = v;
                    end
                    m_acc = 0; m_nblk = 0;
                end
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (falling edge)
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " model hold_word"}, longint'(hold_word), m_hold);
            check({cur_req, " model hold_good"}, longint'(hold_good), longint'(m_good));
        end
    end

    task automatic do_tick(input logic [W-1:0] fw, input logic l, input logic fa);
        @(negedge clk);
        freq_word = fw; lor = l; fast_acq = fa; tick = 1;
        @(negedge clk);
        tick = 0; lor = 0; fast_acq = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_refchg(input logic with_tick);
        @(negedge clk);
        ref_change = 1; tick = with_tick;
        @(negedge clk);
        ref_change = 0; tick = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] saved;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1 reset hold_word", longint'(hold_word), longint'(FR));
        check("R1 reset hold_good", longint'(hold_good), 0);
        rst_n = 1;

        // R2/R6: qualification at tick 101, free-run word before
        cur_req = "R2";
        for (int i = 0; i < QUAL - 1; i++) do_tick(24'd1000, 0, 0);
        check("R2 not good at tick 100", longint'(hold_good), 0);
        check("R6 free-run before qualification", longint'(hold_word), longint'(FR));
        do_tick(24'd1000, 0, 0);
        check("R2 good at tick 101", longint'(hold_good), 1);
        check("R7 no release on qualifying tick", longint'(hold_word), longint'(FR));
        for (int i = 0; i < 3; i++) do_tick(24'd1000, 0, 0);
        cur_req = "R7";
        check("R7 aged average released at tick 104", longint'(hold_word), 1000);

        // R4: varying pattern long enough to wrap the window
        cur_req = "R4";
        for (int i = 0; i < 1150; i++) do_tick(W'(5000 + (i % 37) * 113 + (i / 200) * 7), 0, 0);

        // R5: inhibited ticks
        cur_req = "R5";
        saved = hold_word;
        for (int i = 0; i < 20; i++) do_tick(24'hFFFFFF, 1, 0);
        check("R5 lor keeps hold_word", longint'(hold_word), longint'(saved));
        for (int i = 0; i < 20; i++) do_tick(24'h000001, 0, 1);
        check("R5 fast_acq keeps hold_word", longint'(hold_word), longint'(saved));

        // R8: no tick, freq_word wanders
        cur_req = "R8";
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); freq_word = W'(i * 77777);
        end
        check("R8 idle keeps hold_word", longint'(hold_word), longint'(saved));
        check("R8 idle keeps hold_good", longint'(hold_good), 1);

        // R3/R7: reference change
        cur_req = "R3";
        do_refchg(0);
        check("R3 good cleared after ref_change", longint'(hold_good), 0);
        check("R7 hold kept after ref_change", longint'(hold_word), longint'(saved));
        for (int i = 0; i < QUAL - 1; i++) do_tick(24'd3000, 0, 0);
        check("R3 requalify not before tick 100", longint'(hold_good), 0);
        check("R7 relock keeps last value", longint'(hold_word), longint'(saved));
        do_tick(24'd3000, 0, 0);
        check("R2 requalified at tick 101", longint'(hold_good), 1);
        for (int i = 0; i < 3; i++) do_tick(24'd3000, 0, 0);
        check("R7 new-reference average released", longint'(hold_word), 3000);

        // R3: ref_change with coincident tick, restart qualification
        do_refchg(1);
        check("R3 coincident tick ignored, good low", longint'(hold_good), 0);
        for (int i = 0; i < QUAL - 1; i++) do_tick(24'd4000, 0, 0);
        check("R3 coincident tick not counted", longint'(hold_good), 0);
        do_tick(24'd4000, 0, 0);
        check("R2 good after full restart", longint'(hold_good), 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule